// File: doc/BRIEF.md
# 100 Mbit/s Receive End-of-Stream Detector

This block sits in a 100 Mbit/s receive path, after descrambling and 5-bit code-group alignment. While a packet is being received it looks at each adjacent pair of code groups. A terminate pair, /T/ followed by /R/, ends the packet cleanly. A pair of idle groups, /I/ /I/, ends the packet early and raises an error pulse.

Each accepted code group is held for one strobe before it is forwarded. This delay lets the block see whether a /T/ is followed by /R/ before sending it on. A confirmed terminate pair is never forwarded. Two /I/ groups go downstream in its place. Carrier sense and receive-data-valid stay high for the whole reception. They fall on the cycle after any end.

After an end the block ignores all code groups. It waits for the reception-active input to drop and then rise again. A drop of reception-active in the middle of a packet aborts the packet. The aborted packet gives no error, and the group it was holding is discarded.

Top module: `eos_detector`

## Requirements
- R1: After synchronous active-high reset, `crs`, `rx_dv`, `early_end` and `cg_out_valid` are all 0.
- R2: In the idle state, code groups are ignored. `crs` and `rx_dv` go to 1 on the edge that samples `rx_active`=1. Code groups are accepted from the next edge on.
- R3: During reception, each accepted group leaves on `cg_out` with a one-cycle `cg_out_valid`. It leaves on the edge that accepts the next group, and groups keep their order. Bit 4 of a code group is its first-transmitted bit.
- R4: An accepted /T/ (5'b01101) followed by an accepted /R/ (5'b00111) is replaced by two /I/ groups (5'b11111). These are output on the edge that accepts /R/ and on the edge after it.
- R5: `crs` and `rx_dv` are 0 from the edge that accepts the closing group of a terminate pair or an idle pair. `early_end` stays 0 for a terminate pair.
- R6: Two consecutive accepted /I/ groups during reception give a single-cycle `early_end` pulse on the edge that accepts the second /I/. Both /I/ groups are still output.
- R7: A /T/ that is not followed by /R/ is forwarded unchanged. So is an /I/ that is not followed by /I/.
- R8: After an end, code groups produce no output until `rx_active` has been 0 and then 1 again.
- R9: `rx_active`=0 during reception ends it. `crs` and `rx_dv` are 0 from that edge, there is no `early_end`, and the held group is discarded and never paired with later groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cg_in | input | 5 | Aligned, descrambled code group, bit 4 sent first |
| cg_valid | input | 1 | Strobe: `cg_in` carries a new group this cycle |
| rx_active | input | 1 | Upstream reports that a packet reception is active |
| cg_out | output | 5 | Forwarded code group, with substitutions applied |
| cg_out_valid | output | 1 | `cg_out` carries a group this cycle |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| early_end | output | 1 | One-cycle pulse on a premature (idle-pair) end |

## Verification
The bench builds the block with its default code parameters: /T/=01101, /R/=00111 and /I/=11111. With these values the bench drives every end path with real 5-bit group values. The bench covers several cases:
- a /T/ or /I/ that does not end the packet
- strobes with and without idle gaps
- an abort that leaves a held /T/ which must not pair with a later /R/

A scoreboard queue compares every forwarded group, so any missing, extra or reordered output is caught.

// File: rtl/eos_pkg.sv
package eos_pkg;
  localparam int unsigned CG_W = 5;
  typedef logic [CG_W-1:0] cg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_DRAIN = 2'd2
  } eos_state_e;

  // True when (a, b) in arrival order equals the pattern (pa, pb).
  function automatic logic cg_pair_is(cg_t a, cg_t b, cg_t pa, cg_t pb);
    return (a == pa) && (b == pb);
  endfunction
endpackage

// File: rtl/eos_pair_cmp.sv
module eos_pair_cmp
  import eos_pkg::*;
#(
  parameter cg_t PAT_FIRST  = '0,
  parameter cg_t PAT_SECOND = '0
) (
  input  cg_t  first_cg,
  input  logic first_vld,
  input  cg_t  second_cg,
  output logic hit
);
  assign hit = first_vld && cg_pair_is(first_cg, second_cg, PAT_FIRST, PAT_SECOND);
endmodule

// File: rtl/eos_ctrl.sv
module eos_ctrl
  import eos_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rx_active,
  input  logic cg_valid,
  input  logic esd_hit,
  input  logic ii_hit,
  output logic acc,
  output logic end_evt,
  output logic abort,
  output logic crs,
  output logic rx_dv,
  output logic early_end
);
  eos_state_e state_q, state_n;

  // Named internal events used by the pipeline and the assertions.
  assign abort   = (state_q == ST_RECV) && !rx_active;
  assign acc     = (state_q == ST_RECV) && rx_active && cg_valid;
  assign end_evt = acc && (esd_hit || ii_hit);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (rx_active) state_n = ST_RECV;
      ST_RECV:  if (abort) state_n = ST_IDLE;
                else if (end_evt) state_n = ST_DRAIN;
      ST_DRAIN: if (!rx_active) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      crs       <= 1'b0;
      rx_dv     <= 1'b0;
      early_end <= 1'b0;
    end else begin
      state_q   <= state_n;
      crs       <= (state_n == ST_RECV);
      rx_dv     <= (state_n == ST_RECV);
      early_end <= end_evt && ii_hit;
    end
  end

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    early_end |=> !early_end); // R6
  AST_DROP_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> (!crs && !rx_dv)); // R5
  AST_RISE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(crs) |-> $past(rx_active)); // R2
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!crs && !rx_dv && !early_end)); // R9
endmodule

// File: rtl/eos_pipe.sv
module eos_pipe
  import eos_pkg::*;
#(
  parameter cg_t IDLE_CG = 5'b11111
) (
  input  logic clk,
  input  logic rst,
  input  cg_t  cg_in,
  input  logic acc,
  input  logic end_evt,
  input  logic abort,
  output cg_t  hold_cg,
  output logic hold_vld,
  output cg_t  out_cg,
  output logic out_vld
);
  logic pend_q; // second /I/ still to be emitted

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cg  <= '0;
      hold_vld <= 1'b0;
      out_cg   <= '0;
      out_vld  <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      out_vld <= 1'b0;
      if (end_evt) begin
        out_cg   <= IDLE_CG;
        out_vld  <= 1'b1;
        pend_q   <= 1'b1;
        hold_vld <= 1'b0;
      end else if (pend_q) begin
        out_cg  <= IDLE_CG;
        out_vld <= 1'b1;
        pend_q  <= 1'b0;
      end else if (abort) begin
        hold_vld <= 1'b0;
      end else if (acc) begin
        if (hold_vld) begin
          out_cg  <= hold_cg;
          out_vld <= 1'b1;
        end
        hold_cg  <= cg_in;
        hold_vld <= 1'b1;
      end
    end
  end

  AST_FIRST_IDLE: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> (out_vld && out_cg == IDLE_CG)); // R4
  AST_SECOND_IDLE: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> ##1 (out_vld && out_cg == IDLE_CG)); // R4
  AST_QUIET_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!acc && !end_evt && !pend_q) |=> !out_vld); // R8
endmodule

// File: rtl/eos_detector.sv
module eos_detector
  import eos_pkg::*;
#(
  parameter cg_t TERM_CG = 5'b01101,
  parameter cg_t RES_CG  = 5'b00111,
  parameter cg_t IDLE_CG = 5'b11111
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CG_W-1:0] cg_in,
  input  logic            cg_valid,
  input  logic            rx_active,
  output logic [CG_W-1:0] cg_out,
  output logic            cg_out_valid,
  output logic            crs,
  output logic            rx_dv,
  output logic            early_end
);
  localparam int unsigned N_PAT = 2; // 0: terminate pair, 1: idle pair

  cg_t             hold_cg;
  logic            hold_vld;
  logic [N_PAT-1:0] pat_hit;
  logic            acc, end_evt, abort;

  for (genvar g = 0; g < N_PAT; g++) begin : g_pat
    localparam cg_t PF = (g == 0) ? TERM_CG : IDLE_CG;
    localparam cg_t PS = (g == 0) ? RES_CG  : IDLE_CG;
    eos_pair_cmp #(.PAT_FIRST(PF), .PAT_SECOND(PS)) u_cmp (
      .first_cg (hold_cg),
      .first_vld(hold_vld),
      .second_cg(cg_in),
      .hit      (pat_hit[g])
    );
  end

  eos_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rx_active(rx_active),
    .cg_valid (cg_valid),
    .esd_hit  (pat_hit[0]),
    .ii_hit   (pat_hit[1]),
    .acc      (acc),
    .end_evt  (end_evt),
    .abort    (abort),
    .crs      (crs),
    .rx_dv    (rx_dv),
    .early_end(early_end)
  );

  eos_pipe #(.IDLE_CG(IDLE_CG)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .cg_in   (cg_in),
    .acc     (acc),
    .end_evt (end_evt),
    .abort   (abort),
    .hold_cg (hold_cg),
    .hold_vld(hold_vld),
    .out_cg  (cg_out),
    .out_vld (cg_out_valid)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!crs && !rx_dv && !early_end && !cg_out_valid)); // R1
  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (rst)
    early_end |-> (!crs && $past(crs))); // R6
endmodule

// File: tb/eos_detector_tb.sv
module eos_detector_tb;
  localparam logic [4:0] T_G = 5'b01101;
  localparam logic [4:0] R_G = 5'b00111;
  localparam logic [4:0] I_G = 5'b11111;
  localparam logic [4:0] D0 = 5'b10100, D1 = 5'b01010, D2 = 5'b11110, D3 = 5'b10011;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] cg_in = '0;
  logic cg_valid = 1'b0, rx_active = 1'b0;
  logic [4:0] cg_out;
  logic cg_out_valid, crs, rx_dv, early_end;

  int n_chk = 0, n_fail = 0, n_out = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  eos_detector u_dut (
    .clk(clk), .rst(rst), .cg_in(cg_in), .cg_valid(cg_valid), .rx_active(rx_active),
    .cg_out(cg_out), .cg_out_valid(cg_out_valid), .crs(crs), .rx_dv(rx_dv),
    .early_end(early_end)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [4:0] g, string tag);
    exp_q.push_back(g);
    tag_q.push_back(tag);
  endtask

  // Monitor: pops the scoreboard for every forwarded group.
  always @(negedge clk) begin
    if (!rst && cg_out_valid) begin
      n_out++;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected group actual=%0h expected=none", cg_out);
      end else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cg_out !== e) begin
          n_fail++;
          $display("FAIL %s group actual=%0h expected=%0h", t, cg_out, e);
        end
      end
    end
  end

  task automatic send(logic [4:0] g, int gap);
    cg_in = g;
    cg_valid = 1'b1;
    @(posedge clk); #1;
    cg_valid = 1'b0;
    for (int i = 0; i < gap; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic start_rx();
    rx_active = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R2 crs on start", crs, 1);
    chk("R2 rx_dv on start", rx_dv, 1);
    @(posedge clk); #1;
  endtask

  task automatic stop_rx();
    rx_active = 1'b0;
    repeat (2) begin @(posedge clk); #1; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R3 watchdog actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 crs", crs, 0);
    chk("R1 rx_dv", rx_dv, 0);
    chk("R1 early_end", early_end, 0);
    chk("R1 cg_out_valid", cg_out_valid, 0);

    // R2: strobes while idle are ignored
    @(posedge clk); #1;
    send(D0, 0); send(T_G, 0); send(R_G, 1);
    idle(3);
    chk("R2 idle strobes ignored", n_out, 0);
    chk("R2 crs idle", crs, 0);

    // R3/R4/R5: normal packet with gaps, terminate pair
    start_rx();
    push(D0, "R3"); send(D0, 2);
    push(D1, "R3"); send(D1, 0);
    push(D2, "R3"); send(D2, 1);
    push(D3, "R3"); send(D3, 0);
    push(I_G, "R4"); send(T_G, 0);
    push(I_G, "R4"); send(R_G, 0);
    @(negedge clk);
    chk("R5 crs low after T/R", crs, 0);
    chk("R5 rx_dv low after T/R", rx_dv, 0);
    chk("R5 no error on T/R", early_end, 0);
    idle(2);

    // R8: groups after the end are ignored while rx_active stays high
    seen = n_out;
    send(D0, 0); send(T_G, 0); send(R_G, 0); send(I_G, 0); send(I_G, 0);
    idle(3);
    chk("R8 no output after end", n_out, seen);
    chk("R8 crs stays low", crs, 0);
    stop_rx();

    // R7: /T/ not followed by /R/, /I/ not followed by /I/
    start_rx();
    push(D1, "R3"); send(D1, 0);
    push(T_G, "R7"); send(T_G, 0);
    push(D2, "R7"); send(D2, 0);
    push(I_G, "R7"); send(I_G, 0);
    push(D3, "R7"); send(D3, 0);
    push(I_G, "R4"); send(T_G, 0);
    push(I_G, "R4"); send(R_G, 0);
    idle(3);
    stop_rx();

    // R6: premature end on an idle pair
    start_rx();
    push(D0, "R3"); send(D0, 0);
    push(D2, "R3"); send(D2, 1);
    push(I_G, "R6"); send(I_G, 0);
    push(I_G, "R6"); send(I_G, 0);
    @(negedge clk);
    chk("R6 early_end pulse", early_end, 1);
    chk("R5 crs low after I/I", crs, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R6 early_end single cycle", early_end, 0);
    idle(2);
    stop_rx();

    // R9: abort with a held /T/, then restart with /R/ first
    start_rx();
    push(D1, "R9"); send(D1, 0);
    send(T_G, 0);
    rx_active = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R9 crs low on abort", crs, 0);
    chk("R9 rx_dv low on abort", rx_dv, 0);
    chk("R9 no error on abort", early_end, 0);
    idle(3);
    chk("R9 held group discarded", exp_q.size(), 0);
    start_rx();
    push(R_G, "R9"); send(R_G, 0);
    push(D0, "R9"); send(D0, 0);
    push(I_G, "R4"); send(T_G, 0);
    push(I_G, "R4"); send(R_G, 0);
    idle(3);
    stop_rx();

    idle(4);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule